// File: doc/BRIEF.md
# Latched Far-End Path Defect Status Register

This block holds the far-end path status seen by a receive-side defect detector. The detector reports remote path defect indications as live levels. Two of them, remote alarm indication and remote loss of pointer, arrive on the same remote code, so the block merges them into one server-defect flag. The other two, payload label mismatch and loss of cell delineation, are merged into one payload-defect flag. Once a flag has been raised it stays raised until management clears it on purpose. A persisting defect therefore stays visible, and so does a glitch that came and went between two polls.

Management clears the flags by writing a mask. A flag is cleared only where its mask bit is 1, so clearing one flag never drops another. If a defect is active in the same cycle as a clear, the flag stays set. A read shows the latched state ORed with the live level. The read data arrives one cycle after the read strobe, together with a valid pulse.

Top module: `fe_path_status`

## Requirements
- R1: After reset both latched flags are 0, `rd_valid_o` is 0 and `rd_data_o` is 0.
- R2: Bit 10 of the read word is the payload flag, raised by `plm_i` or `lcd_i`. Bit 8 is the server flag, raised by `ais_i` or `lop_i`.
- R3: A raised flag stays set in later cycles while its sources are low and no clear selects it.
- R4: A write with `wr_en_i` high clears only the flags whose mask bit in `wr_data_i` is 1: bit 10 for the payload flag, bit 8 for the server flag. A flag whose mask bit is 0 is left unchanged.
- R5: If a flag's source is high in the same cycle as a clear that selects it, the flag stays set.
- R6: A read returns, for each flag, the latched value ORed with the live source level in the cycle of the read strobe.
- R7: Bit 9 and every bit other than 8 and 10 always read 0. Writing 1 to those bits has no effect.
- R8: `rd_valid_o` is high in exactly the cycle after each cycle with `rd_en_i` high. `rd_data_o` then carries the word sampled in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ais_i | input | 1 | Live remote alarm-indication defect |
| lop_i | input | 1 | Live remote loss-of-pointer defect |
| plm_i | input | 1 | Live remote payload-label-mismatch defect |
| lcd_i | input | 1 | Live remote loss-of-cell-delineation defect |
| wr_en_i | input | 1 | Clear strobe |
| wr_data_i | input | 16 | Clear mask; 1 clears the flag at that position |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Read word, valid when rd_valid_o is high |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |

## Verification
A latch cell in a wrong state shows up at the ports on the next read strobe: the bit is wrong in the word returned one cycle later. A cell that fails to hold would read 0 after its source drops. A mask wired to the wrong bit would clear the neighbouring flag. A clear that beats a same-cycle set would drop a short event. Reads are placed right after every set, hold, clear and race case, so each wrong state is caught within two cycles of the event that caused it.

// File: rtl/fep_stat_pkg.sv
package fep_stat_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned N_FLAG  = 2;
  localparam int unsigned SRV_POS = 8;   // server flag
  localparam int unsigned RSV_POS = 9;   // reserved, reads zero
  localparam int unsigned PLD_POS = 10;  // payload flag
  localparam int unsigned N_SRC   = 2;   // sources merged per flag

  typedef logic [REG_W-1:0]  reg_word_t;
  typedef logic [N_FLAG-1:0] flag_vec_t;

  function automatic int unsigned flag_pos(int unsigned idx);
    return (idx == 0) ? SRV_POS : PLD_POS;
  endfunction

  function automatic reg_word_t flag_mask();
    reg_word_t m;
    m = '0;
    for (int unsigned k = 0; k < N_FLAG; k++) m[flag_pos(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fep_src_merge.sv
module fep_src_merge #(
  parameter int unsigned N_IN = 2
) (
  input  logic [N_IN-1:0] src_i,
  output logic            any_o
);
  assign any_o = |src_i;
endmodule

// File: rtl/fep_latch_cell.sv
module fep_latch_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (clr_i)  q_q <= 1'b0;
  end

  assign q_o = q_q;

  p_set_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i) |=> q_o);
endmodule

// File: rtl/fep_read_port.sv
module fep_read_port
  import fep_stat_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rd_en_i,
  input  flag_vec_t flags_i,
  output reg_word_t rdata_o,
  output logic      rvalid_o
);
  reg_word_t word_d;
  reg_word_t rdata_q;
  logic      rvalid_q;

  always_comb begin
    word_d = '0;
    for (int unsigned k = 0; k < N_FLAG; k++) word_d[flag_pos(k)] = flags_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= word_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~flag_mask()) == '0);
  p_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
endmodule

// File: rtl/fe_path_status.sv
module fe_path_status
  import fep_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ais_i,
  input  logic             lop_i,
  input  logic             plm_i,
  input  logic             lcd_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  logic [N_SRC-1:0] src [N_FLAG];
  flag_vec_t live, latched, visible;
  reg_word_t wr_data_unused;

  assign src[0] = {lop_i, ais_i};
  assign src[1] = {lcd_i, plm_i};
  assign wr_data_unused = wr_data_i & ~flag_mask();

  for (genvar k = 0; k < N_FLAG; k++) begin : g_flag
    localparam int unsigned POS = flag_pos(k);
    logic clr;
    assign clr = wr_en_i & wr_data_i[POS];

    fep_src_merge #(.N_IN(N_SRC)) u_merge (
      .src_i (src[k]),
      .any_o (live[k])
    );

    fep_latch_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (live[k]),
      .clr_i  (clr),
      .q_o    (latched[k])
    );

    // live level keeps a persisting defect visible right after a clear
    assign visible[k] = latched[k] | live[k];
  end

  fep_read_port u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .flags_i  (visible),
    .rdata_o  (rd_data_o),
    .rvalid_o (rd_valid_o)
  );

  p_live_srv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (ais_i || lop_i)) |=> rd_data_o[SRV_POS]);
  p_live_pld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (plm_i || lcd_i)) |=> rd_data_o[PLD_POS]);
endmodule

// File: tb/sim_fe_path_status.sv
module sim_fe_path_status;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ais = 0, lop = 0, plm = 0, lcd = 0, wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic rd_valid;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic srv_m = 0, pld_m = 0;  // bench model of the latched flags
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fe_path_status u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ais_i(ais), .lop_i(lop), .plm_i(plm),
    .lcd_i(lcd), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, update model, wait next negedge
  task automatic step(input logic a, input logic l, input logic p, input logic c,
                      input logic we, input logic [15:0] wd, input logic re, input string tag);
    logic s_live, p_live;
    ais = a; lop = l; plm = p; lcd = c; wr_en = we; wr_data = wd; rd_en = re;
    s_live = a | l;
    p_live = p | c;
    if (re) begin
      logic [15:0] e;
      e = '0;
      e[8]  = srv_m | s_live;
      e[10] = pld_m | p_live;
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    srv_m = s_live | (srv_m & ~(we & wd[8]));
    pld_m = p_live | (pld_m & ~(we & wd[10]));
    @(negedge clk);
  endtask

  task automatic idle_rd(input string tag);
    step(0, 0, 0, 0, 0, '0, 1, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected valid", rd_data, '0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd_data === e, t, rd_data, e);
        end
      end
    end
  end

  initial begin
    int wd_cnt = 0;
    while (!done) begin
      @(posedge clk);
      wd_cnt++;
      if (wd_cnt > 5000) begin
        chk(0, "watchdog", '0, '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_valid === 1'b0 && rd_data === '0, "R1 reset", rd_data, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    idle_rd("R1 post-reset read");
    step(0, 0, 0, 0, 0, '0, 0, "gap");
    chk(rd_valid === 1'b0, "R8 valid drops", {15'd0, rd_valid}, '0);

    // R2: each source sets its flag
    step(1, 0, 0, 0, 0, '0, 0, "ais");
    idle_rd("R2 ais sets bit8");
    step(0, 0, 0, 0, 1, 16'h0100, 0, "clr");
    step(0, 1, 0, 0, 0, '0, 0, "lop");
    idle_rd("R2 lop sets bit8");
    step(0, 0, 1, 0, 0, '0, 0, "plm");
    idle_rd("R2 plm sets bit10");
    step(0, 0, 0, 0, 1, 16'h0500, 0, "clr both");
    idle_rd("R4 both cleared");
    step(0, 0, 0, 1, 0, '0, 0, "lcd");
    idle_rd("R2 lcd sets bit10 only");

    // R3: hold over idle cycles
    repeat (4) step(0, 0, 0, 0, 0, '0, 0, "idle");
    idle_rd("R3 bit10 held");

    // R4: masked clear
    step(1, 0, 0, 0, 0, '0, 0, "ais");
    step(0, 0, 0, 0, 1, 16'h0100, 0, "clr srv");
    idle_rd("R4 only bit8 cleared");
    step(0, 0, 0, 0, 1, 16'h0000, 0, "empty mask");
    idle_rd("R4 zero mask keeps bit10");
    step(0, 0, 0, 0, 0, 16'h0400, 0, "data no strobe");
    idle_rd("R4 no strobe no clear");
    step(0, 0, 0, 0, 1, 16'h0400, 0, "clr pld");
    idle_rd("R4 bit10 cleared");

    // R5: set and clear race
    step(0, 1, 0, 0, 1, 16'h0100, 0, "race srv");
    idle_rd("R5 set wins bit8");
    step(0, 0, 0, 1, 1, 16'h0500, 0, "race pld");
    idle_rd("R5 set wins bit10, bit8 cleared");
    step(0, 0, 0, 0, 1, 16'h0400, 0, "clr");

    // R6: live level read
    step(0, 0, 1, 0, 0, '0, 1, "R6 live plm on read cycle");
    step(0, 0, 1, 0, 1, 16'h0400, 1, "R6 persisting defect after clear");
    step(1, 0, 0, 0, 1, 16'h0500, 1, "R6 live ais while clearing");
    step(0, 0, 0, 0, 1, 16'h0500, 0, "clr all");
    idle_rd("R6 all clear");

    // R7: reserved bits
    step(0, 0, 0, 0, 1, 16'hFAFF, 0, "rsvd write");
    idle_rd("R7 reserved write no effect");
    step(1, 1, 1, 1, 1, 16'hFFFF, 1, "R7 reserved read zero all set");
    step(0, 0, 0, 0, 1, 16'hFEFF, 0, "clr except bit8");
    idle_rd("R7 bit8 survives mask without it");

    // R8: back-to-back reads
    step(0, 0, 0, 0, 1, 16'h0500, 1, "R8 burst 1");
    idle_rd("R8 burst 2");
    idle_rd("R8 burst 3");
    step(0, 0, 0, 0, 0, '0, 0, "tail");
    step(0, 0, 0, 0, 0, '0, 0, "tail");

    chk(exp_q.size() == 0, "R8 all reads answered", 16'(exp_q.size()), '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule